// File: doc/BRIEF.md
# Shared-Bus Converter Register Writer

This block sits on the logic side of a 10-bit converter whose single data bus carries traffic in both directions. When the converter's output enable is low, the converter drives a sample word onto the bus and the block captures it into a valid-qualified sample stream. To program one of the converter's four internal registers, the block raises output enable so the converter's pins go high-impedance. It then turns on its own bus drivers with a 2-bit address in bits 9:8 and 8 data bits in bits 7:0, and pulses the write strobe. The converter latches the word on the strobe's falling edge.

Every minimum interval between edges is given in nanoseconds and turned into whole clock cycles from a clock-period parameter. Address 3 is a reserved register that must always hold zero. A one in its bit 4 freezes the converter output. For this reason the block clears that register by itself after reset, offers the same clearing write as a one-pulse command, and never lets bit 4 reach that address.

Top module: `adcbus_ctrl`

## Requirements
- R1: While `adc_oe` is low, `bus_drv` is low. A sample taken in a cycle where the block is idle and was not starting a write appears on `smp_data` with `smp_vld` high one cycle later.
- R2: During a write, `bus_out[9:8]` holds the requested address and `bus_out[7:0]` the requested data, and this is the word present while the strobe falls.
- R3: For address 3, bit 4 of the data on the bus is always 0 and the other seven bits pass unchanged. For addresses 0 to 2, all eight bits pass unchanged.
- R4: `adc_oe` is high for exactly max(ceil(12 ns / T), 2) cycles before `adc_wr` rises, where T is the clock period. The strobe is never high while `adc_oe` is low.
- R5: `adc_wr` stays high for exactly max(floor(15 ns / T) + 1, ceil(5 ns / T)) cycles, which is strictly longer than 15 ns and covers the data setup time.
- R6: `bus_drv` is on and `bus_out` is stable from before the strobe rises until ceil(5 ns / T) cycles after it falls.
- R7: After the strobe falls, `adc_oe` stays high for exactly max(ceil(12 ns / T), ceil(5 ns / T) + 1) cycles.
- R8: `bus_drv` is off in the first cycle of `adc_oe` high and off again before `adc_oe` falls.
- R9: `adc_wr` is low throughout reset. After reset releases, the first write issued starts by itself and is address 3 with data 0x00.
- R10: A one-cycle `clr_req` issues the same address-3, data-0x00 write. If `clr_req` and `wr_req` are high in the same cycle, only the clearing write is issued.
- R11: `busy` is high from the cycle after a request is accepted until the sequence ends. Requests that arrive while `busy` is high are dropped and produce no write.
- R12: `smp_vld` is low whenever `busy` is high. Once the block has been idle with `adc_oe` low for two cycles, `smp_vld` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | One-cycle register write request |
| wr_addr | input | 2 | Register address for the request |
| wr_data | input | 8 | Register data for the request |
| clr_req | input | 1 | One-cycle request to clear the reserved register |
| bus_in | input | 10 | Bus value seen at the pads |
| adc_oe | output | 1 | Converter output enable (high: converter pins released) |
| adc_wr | output | 1 | Converter write strobe |
| bus_drv | output | 1 | Tri-state enable for the block's bus drivers |
| bus_out | output | 10 | Word driven when `bus_drv` is high |
| busy | output | 1 | Write sequence pending or running |
| smp_vld | output | 1 | Sample output valid |
| smp_data | output | 10 | Captured sample word |

## Verification
`busy` is due one cycle after the edge that accepts a request. `adc_oe` rises on that same edge. The strobe, the driver enable and the release of `adc_oe` then follow at the phase lengths set by R4 to R7. The bench drives inputs on falling edges and watches the pins on every falling edge. It measures each interval as a run of cycles and compares it with a length it works out from the nanosecond limits for a 4 ns period parameter. A captured sample is due one cycle after the bus value it copies. The bench therefore registers `bus_in` on the rising edge and compares `smp_data` against that copy half a cycle later.

// File: rtl/adcbus_pkg.sv
package adcbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OEHI,
    PH_PRE,
    PH_STB,
    PH_HOLD,
    PH_POST
  } phase_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // cycles covering at least ns nanoseconds, never less than one
  function automatic int ns_ceil(input int ns, input int clk_ps);
    return max2((ns * 1000 + clk_ps - 1) / clk_ps, 1);
  endfunction

  // cycles lasting strictly longer than ns nanoseconds
  function automatic int ns_over(input int ns, input int clk_ps);
    return (ns * 1000) / clk_ps + 1;
  endfunction

endpackage

// File: rtl/adcbus_wrfmt.sv
module adcbus_wrfmt #(
  parameter int AW       = 2,
  parameter int DW       = 8,
  parameter int RSV_ADDR = 3,
  parameter int LOCK_BIT = 4
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  output logic [AW+DW-1:0] word_o
);
  logic to_rsv;
  assign to_rsv = (addr_i == AW'(RSV_ADDR));
  assign word_o[AW+DW-1:DW] = addr_i;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i == LOCK_BIT) begin : g_lock
      assign word_o[i] = data_i[i] & ~to_rsv;
    end else begin : g_pass
      assign word_o[i] = data_i[i];
    end
  end
endmodule

// File: rtl/adcbus_seq.sv
module adcbus_seq
  import adcbus_pkg::*;
#(
  parameter int CLK_PS    = 20000,
  parameter int BW        = 10,
  parameter int DW        = 8,
  parameter int RSV_ADDR  = 3,
  parameter int OE2STB_NS = 12,
  parameter int STB_NS    = 15,
  parameter int SETUP_NS  = 5,
  parameter int HOLD_NS   = 5,
  parameter int STB2OE_NS = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          clr_req,
  input  logic [BW-1:0] user_word,
  output logic          oe_o,
  output logic          wr_o,
  output logic          drv_o,
  output logic [BW-1:0] word_o,
  output logic          busy_o,
  output logic          start_o
);
  localparam int L_OEHI = 1;
  localparam int L_PRE  = max2(ns_ceil(OE2STB_NS, CLK_PS) - 1, 1);
  localparam int L_STB  = max2(ns_over(STB_NS, CLK_PS), ns_ceil(SETUP_NS, CLK_PS));
  localparam int L_HOLD = ns_ceil(HOLD_NS, CLK_PS);
  localparam int L_POST = max2(ns_ceil(STB2OE_NS, CLK_PS) - L_HOLD, 1);
  localparam int L_MAX  = max2(max2(L_PRE, L_STB), max2(L_HOLD, L_POST));
  localparam int CW     = $clog2(L_MAX + 1);
  localparam int SUMALL = L_OEHI + L_PRE + L_STB + L_HOLD + L_POST;
  localparam int RW     = $clog2(SUMALL + 2) + 1;
  localparam logic [BW-1:0] CLR_WORD = {(BW-DW)'(RSV_ADDR), DW'(0)};

  phase_t        ph, ph_nx;
  logic [CW-1:0] cnt, len_nx;
  logic          clr_pend;
  logic          use_clr;

  assign use_clr = clr_pend | clr_req;
  assign start_o = (ph == PH_IDLE) & (use_clr | wr_req);

  always_comb begin
    ph_nx  = PH_IDLE;
    len_nx = CW'(0);
    case (ph)
      PH_OEHI: begin ph_nx = PH_PRE;  len_nx = CW'(L_PRE - 1);  end
      PH_PRE:  begin ph_nx = PH_STB;  len_nx = CW'(L_STB - 1);  end
      PH_STB:  begin ph_nx = PH_HOLD; len_nx = CW'(L_HOLD - 1); end
      PH_HOLD: begin ph_nx = PH_POST; len_nx = CW'(L_POST - 1); end
      default: begin ph_nx = PH_IDLE; len_nx = CW'(0);          end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      word_o   <= '0;
      clr_pend <= 1'b1;
    end else if (ph == PH_IDLE) begin
      if (start_o) begin
        ph       <= PH_OEHI;
        cnt      <= CW'(L_OEHI - 1);
        word_o   <= use_clr ? CLR_WORD : user_word;
        clr_pend <= 1'b0;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      ph  <= ph_nx;
      cnt <= len_nx;
    end
  end

  assign oe_o   = (ph != PH_IDLE);
  assign wr_o   = (ph == PH_STB);
  assign drv_o  = (ph == PH_PRE) | (ph == PH_STB) | (ph == PH_HOLD);
  assign busy_o = (ph != PH_IDLE) | clr_pend;

  // run-length observers for the timing assertions
  logic [RW-1:0] oe_run, stb_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_run  <= '0;
      stb_run <= '0;
    end else begin
      oe_run  <= oe_o ? oe_run + 1'b1 : '0;
      stb_run <= wr_o ? stb_run + 1'b1 : '0;
    end
  end

  p_stb_in_oe_r4: assert property (@(posedge clk) disable iff (!rst_n) wr_o |-> oe_o);
  p_oe_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_o) |-> (oe_run == RW'(L_OEHI + L_PRE)));
  p_stb_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_o) |-> (stb_run == RW'(L_STB)));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n) $fell(wr_o) |-> drv_o);
  p_bus_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_o && $past(drv_o)) |-> $stable(word_o));
  p_drv_in_oe_r8: assert property (@(posedge clk) disable iff (!rst_n) drv_o |-> oe_o);
  p_drv_late_r8: assert property (@(posedge clk) disable iff (!rst_n) $rose(oe_o) |-> !drv_o);

  always @(negedge clk) begin
    if (!rst_n) p_wr_low_reset_r9: assert (!wr_o);
  end
endmodule

// File: rtl/adcbus_capture.sv
module adcbus_capture #(
  parameter int BW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic [BW-1:0] bus_i,
  output logic          vld_o,
  output logic [BW-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      data_o <= '0;
    end else begin
      vld_o <= take_i;
      if (take_i) data_o <= bus_i;
    end
  end
endmodule

// File: rtl/adcbus_ctrl.sv
module adcbus_ctrl
  import adcbus_pkg::*;
#(
  parameter int CLK_PS    = 20000,
  parameter int AW        = 2,
  parameter int DW        = 8,
  parameter int RSV_ADDR  = 3,
  parameter int LOCK_BIT  = 4,
  parameter int OE2STB_NS = 12,
  parameter int STB_NS    = 15,
  parameter int SETUP_NS  = 5,
  parameter int HOLD_NS   = 5,
  parameter int STB2OE_NS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             clr_req,
  input  logic [AW+DW-1:0] bus_in,
  output logic             adc_oe,
  output logic             adc_wr,
  output logic             bus_drv,
  output logic [AW+DW-1:0] bus_out,
  output logic             busy,
  output logic             smp_vld,
  output logic [AW+DW-1:0] smp_data
);
  localparam int BW = AW + DW;

  logic [BW-1:0] user_word;
  logic          start;
  logic          take;

  adcbus_wrfmt #(.AW(AW), .DW(DW), .RSV_ADDR(RSV_ADDR), .LOCK_BIT(LOCK_BIT)) u_fmt (
    .addr_i(wr_addr), .data_i(wr_data), .word_o(user_word)
  );

  adcbus_seq #(
    .CLK_PS(CLK_PS), .BW(BW), .DW(DW), .RSV_ADDR(RSV_ADDR),
    .OE2STB_NS(OE2STB_NS), .STB_NS(STB_NS), .SETUP_NS(SETUP_NS),
    .HOLD_NS(HOLD_NS), .STB2OE_NS(STB2OE_NS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .clr_req(clr_req),
    .user_word(user_word), .oe_o(adc_oe), .wr_o(adc_wr), .drv_o(bus_drv),
    .word_o(bus_out), .busy_o(busy), .start_o(start)
  );

  assign take = ~busy & ~start;

  adcbus_capture #(.BW(BW)) u_cap (
    .clk(clk), .rst_n(rst_n), .take_i(take), .bus_i(bus_in),
    .vld_o(smp_vld), .data_o(smp_data)
  );

  p_lockbit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_drv && bus_out[BW-1:DW] == AW'(RSV_ADDR)) |-> !bus_out[LOCK_BIT]);
  p_no_vld_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !smp_vld);
  p_no_drv_oe_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_oe |-> !bus_drv);
endmodule

// File: tb/sim_adcbus_ctrl.sv
module sim_adcbus_ctrl;
  localparam int CP = 4000;  // period parameter in ps handed to the design

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_req = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       clr_req = 1'b0;
  logic [9:0] bus_in = '0;
  logic       adc_oe, adc_wr, bus_drv, busy, smp_vld;
  logic [9:0] bus_out, smp_data;

  adcbus_ctrl #(.CLK_PS(CP)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .clr_req(clr_req), .bus_in(bus_in), .adc_oe(adc_oe), .adc_wr(adc_wr),
    .bus_drv(bus_drv), .bus_out(bus_out), .busy(busy), .smp_vld(smp_vld),
    .smp_data(smp_data)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int cdiv(input int ns);
    int c;
    c = (ns * 1000 + CP - 1) / CP;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  int exp_lead, exp_whi, exp_setup, exp_hold, exp_post;
  initial begin
    exp_lead  = mx(cdiv(12), 2);
    exp_whi   = mx(15000 / CP + 1, cdiv(5));
    exp_setup = cdiv(5);
    exp_hold  = cdiv(5);
    exp_post  = mx(cdiv(12), cdiv(5) + 1);
  end

  logic [9:0] bus_edge;
  always @(posedge clk) bus_edge <= bus_in;

  logic [9:0] exp_word = 10'h300;
  logic [9:0] last_word = '0;
  logic [9:0] cap_word = '0;
  int nwrites = 0;
  bit p_oe = 0, p_wr = 0, p_drv = 0, after = 0, first_drv = 0;
  logic [9:0] p_bus = '0;
  int lead, whi, drun, setup_seen, hold, post, ovl = 0, idle_run = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(adc_wr == 1'b0, "R9 strobe in reset", adc_wr, 0);
      p_oe = 0; p_wr = 0; p_drv = 0; idle_run = 0;
    end else begin
      if (adc_oe && !p_oe) begin
        lead = 0; whi = 0; drun = 0; setup_seen = 0; hold = 0; post = 0;
        after = 0; first_drv = bus_drv;
      end
      if (bus_drv && !adc_oe) ovl++;
      if (adc_oe && !adc_wr && !after && whi == 0) lead++;
      if (adc_wr) whi++;
      if (!after) drun = bus_drv ? drun + 1 : 0;
      if (!adc_wr && p_wr) begin
        after = 1; cap_word = p_bus; setup_seen = drun - 1; nwrites++;
      end
      if (after) begin
        if (adc_oe) post++;
        if (bus_drv) hold++;
      end
      if (!adc_oe && p_oe) begin
        chk(cap_word == exp_word, (exp_word[9:8] == 2'd3) ? "R3 word" : "R2 word",
            cap_word, exp_word);
        chk(lead == exp_lead, "R4 oe lead", lead, exp_lead);
        chk(whi == exp_whi, "R5 strobe width", whi, exp_whi);
        chk(setup_seen >= exp_setup, "R6 setup", setup_seen, exp_setup);
        chk(hold == exp_hold, "R6 hold", hold, exp_hold);
        chk(post == exp_post, "R7 oe tail", post, exp_post);
        chk(!first_drv, "R8 drive late", first_drv, 0);
        last_word = cap_word;
      end
      // sample stream
      if (busy) chk(!smp_vld, "R12 vld while busy", smp_vld, 0);
      if (smp_vld) chk(smp_data == bus_edge, "R1 sample", smp_data, bus_edge);
      if (!busy && !adc_oe) idle_run++; else idle_run = 0;
      if (idle_run >= 3) chk(smp_vld, "R12 vld idle", smp_vld, 1);
      p_oe = adc_oe; p_wr = adc_wr; p_drv = bus_drv; p_bus = bus_out;
    end
    bus_in = bus_in + 10'd37;
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    int n0;
    wait_idle();
    n0 = nwrites;
    exp_word = {a, (a == 2'd3) ? (d & 8'hEF) : d};
    wr_req = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_req = 1'b0;
    chk(busy, "R11 busy after accept", busy, 1);
    wait_idle();
    chk(nwrites == n0 + 1, "R2 one write", nwrites, n0 + 1);
  endtask

  int cyc = 0;
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int n0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R9: automatic clearing write
    wait_idle();
    chk(nwrites == 1, "R9 auto write count", nwrites, 1);
    chk(last_word == 10'h300, "R9 auto write word", last_word, 10'h300);
    chk(ovl == 0, "R1 no overlap after init", ovl, 0);

    // R2 sweep of function registers
    for (int a = 0; a < 3; a++)
      for (int k = 0; k < 8; k++)
        do_write(2'(a), 8'((k * 37) ^ (8'h01 << k)));
    // R3: every data value to the reserved address
    for (int d = 0; d < 256; d++) do_write(2'd3, 8'(d));

    // R11: request during busy is dropped
    wait_idle();
    n0 = nwrites;
    exp_word = 10'h1A5;
    wr_req = 1'b1; wr_addr = 2'd1; wr_data = 8'hA5;
    @(negedge clk);
    wr_addr = 2'd2; wr_data = 8'h3C;
    @(negedge clk);
    wr_req = 1'b0;
    wait_idle();
    chk(nwrites == n0 + 1, "R11 dropped request count", nwrites, n0 + 1);
    chk(last_word == 10'h1A5, "R11 dropped request word", last_word, 10'h1A5);

    // R10: clear command with priority over a write request
    wait_idle();
    n0 = nwrites;
    exp_word = 10'h300;
    clr_req = 1'b1; wr_req = 1'b1; wr_addr = 2'd2; wr_data = 8'h77;
    @(negedge clk);
    clr_req = 1'b0; wr_req = 1'b0;
    wait_idle();
    chk(nwrites == n0 + 1, "R10 clear count", nwrites, n0 + 1);
    chk(last_word == 10'h300, "R10 clear word", last_word, 10'h300);

    // R10: clear alone, then idle sampling (R12)
    wait_idle();
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    wait_idle();
    chk(last_word == 10'h300, "R10 lone clear", last_word, 10'h300);
    repeat (20) @(negedge clk);
    chk(smp_vld, "R12 stream resumed", smp_vld, 1);
    chk(ovl == 0, "R1 drive never with oe low", ovl, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule